// File: doc/BRIEF.md
# All-Busy Protocol Interrupt Scheduler

This block sits beside a message queue that is served by a small pool of worker processors. Each worker is in one of three states: polling for work, computing application code, or running a protocol handler. When work is pending and some worker is polling, the work goes to that worker with no interrupt. Only when no worker is polling is one computing worker interrupted, so that pending work never waits forever behind busy workers. Repeated interrupts are spread over the workers by a rotating pointer.

Workers report their state with two write strobes. One says "back to computing" and the other says "handler finished". A handed-out event is signalled to the chosen worker by a one-cycle notify pulse, which tells it to re-read its dispatch slot instead of trusting a stale copy. All outputs are registered. Each one shows the effect of the inputs sampled at one rising clock edge, directly after that edge.

Top module: `allbusy_irq_sched`

## Requirements
- R1: After reset every worker is polling, the rotating pointer is 0, and all `irq` and `dispatch_notify` bits are 0.
- R2: If `event_pending` is high and at least one worker is polling, the lowest-index polling worker is given the event. Its `dispatch_notify` bit is high for the one cycle after the edge, that worker enters the handling state, and no interrupt is raised.
- R3: An interrupt is raised only when all of these hold at the same edge: `event_pending` is high, no worker is polling, no interrupt is outstanding, and at least one worker is computing. Otherwise no `irq` bit rises.
- R4: The interrupted worker is the first computing worker found at or after the pointer, searching upward with wrap from 3 to 0. The pointer then moves to that worker's index plus one, modulo the worker count.
- R5: Raising an interrupt also dispatches the event. In the same cycle that the `irq` bit rises, the same worker's `dispatch_notify` bit pulses, and that worker enters the handling state.
- R6: At most one `irq` bit is high. It stays high until the edge after the interrupted worker's `irq_ack` bit is sampled high, or until the edge after a cycle in which some worker is polling.
- R7: A `resume_wr[i]` strobe puts worker i into computing. A `done_wr[i]` strobe puts worker i into polling. If both arrive together, computing wins. A strobe in the same cycle as a dispatch to that worker overrides the dispatch.
- R8: At most one `dispatch_notify` bit is high in any cycle, and each dispatch gives exactly one one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| event_pending | input | 1 | A protocol event is waiting to be handed out |
| resume_wr | input | NPROC | Per-worker strobe: worker returns to computing |
| done_wr | input | NPROC | Per-worker strobe: handler finished, worker polls |
| irq_ack | input | NPROC | Per-worker interrupt acknowledge |
| irq | output | NPROC | Per-worker interrupt line, at most one high |
| dispatch_notify | output | NPROC | Per-worker one-cycle pulse: event handed to this worker |

## Verification
Every result of this block, whether a notify pulse, an interrupt rising or an interrupt falling, is due exactly one rising edge after the inputs that cause it are sampled. The bench drives inputs at the falling edge, lets one rising edge pass, and compares both output vectors at the next falling edge against a bench model stepped with the same inputs. Clearing an interrupt is judged on the state before the edge. So a worker that turns to polling at edge k drops the interrupt at edge k+1, and directed cases check that one-cycle lag explicitly.

// File: rtl/abis_pkg.sv
package abis_pkg;

    typedef enum logic [1:0] {
        PS_POLL    = 2'd0,
        PS_COMPUTE = 2'd1,
        PS_HANDLE  = 2'd2
    } pstate_e;

endpackage

// File: rtl/abis_rr_pick.sv
module abis_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] start,
    output logic [N-1:0]  gnt,
    output logic [PW-1:0] idx,
    output logic          found
);
    int j;

    // first requester at or above start, wrapping past N-1
    always_comb begin
        gnt   = '0;
        idx   = '0;
        found = 1'b0;
        j     = 0;
        for (int k = 0; k < N; k++) begin
            j = int'(start) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found  = 1'b1;
                gnt[j] = 1'b1;
                idx    = PW'(j);
            end
        end
    end
endmodule

// File: rtl/abis_proc_next.sv
module abis_proc_next
    import abis_pkg::*;
(
    input  pstate_e cur,
    input  logic    take,
    input  logic    resume_wr,
    input  logic    done_wr,
    output pstate_e nxt
);
    // dispatch first, then strobes; resume beats done (R7)
    always_comb begin
        nxt = cur;
        if (take)      nxt = PS_HANDLE;
        if (done_wr)   nxt = PS_POLL;
        if (resume_wr) nxt = PS_COMPUTE;
    end
endmodule

// File: rtl/allbusy_irq_sched.sv
module allbusy_irq_sched
    import abis_pkg::*;
#(
    parameter int NPROC = 4,
    localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_pending,
    input  logic [NPROC-1:0] resume_wr,
    input  logic [NPROC-1:0] done_wr,
    input  logic [NPROC-1:0] irq_ack,
    output logic [NPROC-1:0] irq,
    output logic [NPROC-1:0] dispatch_notify
);
    typedef struct packed {
        pstate_e [NPROC-1:0] st;
        logic [NPROC-1:0]    irq;
        logic [NPROC-1:0]    ntf;
        logic [PW-1:0]       ptr;
    } sched_s;

    sched_s r_d, r_q;

    logic [NPROC-1:0] poll_vec, cmp_vec, poll_gnt, cmp_gnt, take;
    logic [PW-1:0]    poll_idx, cmp_idx;
    logic             any_poll, cmp_found, irq_busy, clr, raise, disp_idle;
    pstate_e          st_nxt [NPROC];

    genvar g;
    generate
        for (g = 0; g < NPROC; g++) begin : g_proc
            assign poll_vec[g] = (r_q.st[g] == PS_POLL);
            assign cmp_vec[g]  = (r_q.st[g] == PS_COMPUTE);
            abis_proc_next i_next (
                .cur       (r_q.st[g]),
                .take      (take[g]),
                .resume_wr (resume_wr[g]),
                .done_wr   (done_wr[g]),
                .nxt       (st_nxt[g])
            );
        end
    endgenerate

    // polling workers: fixed priority, lowest index first
    abis_rr_pick #(.N(NPROC), .PW(PW)) i_poll_pick (
        .req   (poll_vec),
        .start ('0),
        .gnt   (poll_gnt),
        .idx   (poll_idx),
        .found (any_poll)
    );

    // computing workers: rotating start for interrupts
    abis_rr_pick #(.N(NPROC), .PW(PW)) i_cmp_pick (
        .req   (cmp_vec),
        .start (r_q.ptr),
        .gnt   (cmp_gnt),
        .idx   (cmp_idx),
        .found (cmp_found)
    );

    assign irq_busy  = |r_q.irq;
    assign clr       = irq_busy && (((r_q.irq & irq_ack) != '0) || any_poll);
    assign disp_idle = event_pending && any_poll;
    assign raise     = event_pending && !any_poll && !irq_busy && cmp_found;
    assign take      = disp_idle ? poll_gnt : (raise ? cmp_gnt : '0);

    always_comb begin
        r_d     = r_q;
        r_d.ntf = take;
        if (clr) r_d.irq = '0;
        if (raise) begin
            r_d.irq = cmp_gnt;
            r_d.ptr = (cmp_idx == PW'(NPROC - 1)) ? '0 : cmp_idx + 1'b1;
        end
        for (int i = 0; i < NPROC; i++) r_d.st[i] = st_nxt[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq             = r_q.irq;
    assign dispatch_notify = r_q.ntf;

    // ---------------- assertions ----------------
    p_irq_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));

    p_notify_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dispatch_notify));

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) != '0) |-> ($past(event_pending) && !$past(any_poll)));

    p_irq_with_notify_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) != '0) |-> ((irq & ~$past(irq)) == dispatch_notify));

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq != '0) && !any_poll && ((irq & irq_ack) == '0)) |=> (irq == $past(irq)));

    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(r_q.ptr) < NPROC));

endmodule

// File: tb/test_allbusy_irq_sched.sv
module test_allbusy_irq_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          event_pending = 1'b0;
    logic [NP-1:0] resume_wr = '0;
    logic [NP-1:0] done_wr = '0;
    logic [NP-1:0] irq_ack = '0;
    logic [NP-1:0] irq, dispatch_notify;

    int checks = 0;
    int fails  = 0;

    // bench model: 0 poll, 1 compute, 2 handle
    int            m_st [NP];
    int            m_ptr;
    logic [NP-1:0] m_irq, m_ntf;

    always #(CLK_PERIOD/2) clk = ~clk;

    allbusy_irq_sched #(.NPROC(NP)) i_allbusy_irq_sched (
        .clk             (clk),
        .rst_n           (rst_n),
        .event_pending   (event_pending),
        .resume_wr       (resume_wr),
        .done_wr         (done_wr),
        .irq_ack         (irq_ack),
        .irq             (irq),
        .dispatch_notify (dispatch_notify)
    );

    function automatic bit any_poll_m();
        for (int i = 0; i < NP; i++) if (m_st[i] == 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_step(input logic ev, input logic [NP-1:0] res,
                              input logic [NP-1:0] dn, input logic [NP-1:0] ack);
        bit            anyp = any_poll_m();
        bit            clr  = (m_irq != '0) && (((m_irq & ack) != '0) || anyp);
        logic [NP-1:0] tk   = '0;
        logic [NP-1:0] nirq = m_irq;
        int            nptr = m_ptr;
        if (ev && anyp) begin
            for (int i = NP - 1; i >= 0; i--) if (m_st[i] == 0) tk = NP'(1) << i;
        end else if (ev && (m_irq == '0)) begin
            for (int k = NP - 1; k >= 0; k--) begin
                int j = (m_ptr + k) % NP;
                if (m_st[j] == 1) begin
                    tk   = NP'(1) << j;
                    nptr = (j + 1) % NP;
                end
            end
        end
        if (clr) nirq = '0;
        if (!anyp && tk != '0) nirq = tk;
        for (int i = 0; i < NP; i++) begin
            if (tk[i])  m_st[i] = 2;
            if (dn[i])  m_st[i] = 0;
            if (res[i]) m_st[i] = 1;
        end
        m_irq = nirq;
        m_ntf = tk;
        m_ptr = nptr;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge pass, sample at next falling edge
    task automatic cyc(input logic ev, input logic [NP-1:0] res,
                       input logic [NP-1:0] dn, input logic [NP-1:0] ack, input string tag);
        event_pending = ev;
        resume_wr     = res;
        done_wr       = dn;
        irq_ack       = ack;
        model_step(ev, res, dn, ack);
        @(posedge clk);
        @(negedge clk);
        check(tag, "irq", irq, m_irq);
        check(tag, "notify", dispatch_notify, m_ntf);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NP; i++) m_st[i] = 0;
        m_ptr = 0; m_irq = '0; m_ntf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "irq reset", irq, '0);
        check("R1", "notify reset", dispatch_notify, '0);

        // R2: polling workers take events, lowest index first
        cyc(1'b1, '0, '0, '0, "R2");
        check("R2", "notify to worker 0", dispatch_notify, 4'b0001);
        cyc(1'b1, '0, '0, '0, "R2");
        check("R2", "notify to worker 1", dispatch_notify, 4'b0010);
        // R7: done in the same cycle as a dispatch elsewhere; worker 0 polls again
        cyc(1'b1, '0, 4'b0001, '0, "R7");
        cyc(1'b1, '0, '0, '0, "R7");
        check("R7", "worker 0 polling again", dispatch_notify, 4'b0001);

        // all computing, then one event: R3 and R5
        cyc(1'b0, 4'b1111, '0, '0, "R7");
        cyc(1'b1, '0, '0, '0, "R3");
        check("R3", "irq to worker 0", irq, 4'b0001);
        check("R5", "notify with irq", dispatch_notify, 4'b0001);
        cyc(1'b1, '0, '0, '0, "R6");
        check("R6", "irq held while outstanding", irq, 4'b0001);
        check("R8", "single pulse", dispatch_notify, 4'b0000);
        cyc(1'b1, '0, '0, 4'b0001, "R6");
        check("R6", "irq dropped after ack", irq, 4'b0000);
        cyc(1'b1, '0, '0, '0, "R4");
        check("R4", "irq rotates to worker 1", irq, 4'b0010);

        // R6: a polling worker clears the interrupt one edge later
        cyc(1'b0, '0, 4'b0100, '0, "R6");
        cyc(1'b0, '0, '0, '0, "R6");
        check("R6", "irq dropped by polling worker", irq, 4'b0000);
        // R7: resume and done together -> computing
        cyc(1'b0, 4'b0100, 4'b0100, '0, "R7");

        // R4 wrap: pointer 2, walk 2 -> 3 -> 0
        cyc(1'b1, 4'b1000, '0, '0, "R4");
        cyc(1'b1, '0, '0, 4'b1111, "R4");
        cyc(1'b1, '0, '0, '0, "R4");
        cyc(1'b0, 4'b0011, '0, 4'b1111, "R4");
        cyc(1'b1, '0, '0, '0, "R4");
        check("R4", "irq wraps to worker 0", irq, 4'b0001);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [NP-1:0] r, d, a;
            for (int i = 0; i < NP; i++) begin
                r[i] = ($urandom % 8) == 0;
                d[i] = ($urandom % 6) == 0;
                a[i] = ($urandom % 4) == 0;
            end
            cyc(($urandom % 3) != 0, r, d, a, "R5 R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule